// File: doc/BRIEF.md
# Key Snapshot Queue with Occupancy Interrupt

This block sits between a keyboard matrix scanner and a processor. Each time the scanner finishes a pass it offers one snapshot: eight one-byte key entries, each byte carrying a valid flag, a row number and a column number. The block queues these snapshots in a small first-in first-out store and lets software fetch them through four word-wide registers. Those registers are a control word, an interrupt status word and two read-only entry words that together show the oldest snapshot.

Software sets the queue level at which an interrupt is wanted. The block raises a sticky status flag when that level is reached, and it drives an active-high level interrupt when the flag and its enable are both set. Reading the upper entry word removes the oldest snapshot. Firmware empties the queue by reading both entry words repeatedly until the occupancy field reads zero. The control word also carries the scan enable and the debounce count, which are passed straight out to the scanner.

Top module: `keysnap_fifo`

## Requirements
- R1: After reset the occupancy is 0, the threshold status is clear, `irq` is low, the control word reads 0 and `bus_rdata` is 0.
- R2: A snapshot offered on `snap_valid` is queued only while control bit 0 (enable) is 1. With enable at 0 the offer is ignored and the occupancy does not change.
- R3: When the occupancy equals DEPTH, an offered snapshot is dropped. The occupancy stays at DEPTH and the stored snapshots come out unchanged and in order.
- R4: Register address 2 (low entry word) returns bytes 0..3 of the oldest snapshot, with entry 0 in bits 7:0. Address 3 (high entry word) returns bytes 4..7. Each byte is stored as given: bit 7 valid, bits 6:3 row, bits 2:0 column.
- R5: A read of address 3 removes the oldest snapshot when the queue is not empty. A read of address 2 never removes one. Snapshots leave in the order they arrived.
- R6: When the queue is empty, both entry words read 0 (so no valid flag is set), and a read of address 3 leaves the occupancy at 0.
- R7: Status word (address 1) bits 7:4 show the current occupancy. Its other bits, apart from bit 2, read 0.
- R8: Status bit 2 becomes 1 one cycle after the occupancy is at or above the threshold in control bits 17:14, provided that threshold is nonzero. A threshold of 0 never sets it.
- R9: Status bit 2 stays set until software writes a 1 to bit 2 of address 1. Writing 0 there has no effect. If the threshold condition still holds in the same cycle as the clear, the bit stays set.
- R10: `irq` is high exactly when status bit 2 and control bit 3 (interrupt enable) are both 1.
- R11: Control bits 0, 3, 13:4 (debounce) and 17:14 (threshold) read back as written, and all other control bits read 0. `scan_enable` and `scan_debounce` follow bits 0 and 13:4.
- R12: A read strobe at one clock edge places the addressed word on `bus_rdata` after that edge, and `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_valid | input | 1 | Scanner offers a snapshot this cycle |
| snap_data | input | 64 | Snapshot: eight key bytes, entry 0 in bits 7:0 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 low entry word, 3 high entry word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Active-high level interrupt |
| scan_enable | output | 1 | Enable passed to the scanner |
| scan_debounce | output | 10 | Debounce count passed to the scanner |

## Verification
A table of snapshots is run through the queue one at a time. The table includes all-zero, all-ones, mixed-byte and single-entry patterns, so that a swapped word, a misplaced byte or a lost entry shows up as a mismatch in one of the two entry words. Directed sequences then fill the queue past DEPTH, which separates dropping a new snapshot from overwriting an old one, and drain it to check arrival order. The threshold is crossed with the interrupt enabled and again with it disabled, and the status bit is cleared both while the condition still holds and after it has gone. Reads of the low word without a following high-word read, and offers made while enable is off, confirm that neither changes the occupancy.

// File: rtl/keysnap_pkg.sv
package keysnap_pkg;
    localparam int SNAP_W    = 64;
    localparam int WORD_W    = 32;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 3;
    localparam int DEB_LSB   = 4;
    localparam int DEB_W     = 10;
    localparam int THR_LSB   = 14;
    localparam int THR_W     = 4;
    localparam int STAT_THR  = 2;
    localparam int OCC_LSB   = 4;
    localparam int OCC_W     = 4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_STAT   = 2'd1,
        REG_ENT_LO = 2'd2,
        REG_ENT_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [DEB_W-1:0] deb;
        logic             irq_en;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/keysnap_store.sv
module keysnap_store
    import keysnap_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [SNAP_W-1:0] wr_data,
    output logic [SNAP_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [SNAP_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop, is_full, is_empty;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.cnt == CNT_W'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_push  = push && !is_full;
        do_pop   = pop && !is_empty;
        if (do_push) st_d.wp = wrap_inc(st_q.wp);
        if (do_pop)  st_d.rp = wrap_inc(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wr_data;
    end

    assign head  = is_empty ? '0 : mem_q[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/keysnap_regs.sv
module keysnap_regs
    import keysnap_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [SNAP_W-1:0] head,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              pop,
    output ctrl_t             ctrl,
    output logic              thr_status,
    output logic              irq
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              thr_st;
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t      st_d, st_q;
    reg_sel_e sel;
    logic     hit, clr;
    logic     unused_wdata;

    function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_EN]              = c.en;
        w[CTRL_IE]              = c.irq_en;
        w[DEB_LSB +: DEB_W]     = c.deb;
        w[THR_LSB +: THR_W]     = c.thr;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] stat_word(input logic [CNT_W-1:0] occ,
                                                    input logic flag);
        logic [WORD_W-1:0] w;
        w = '0;
        w[OCC_LSB +: OCC_W] = OCC_W'(occ);
        w[STAT_THR]         = flag;
        return w;
    endfunction

    always_comb begin
        st_d = st_q;
        sel  = reg_sel_e'(bus_addr);
        if (bus_wr && sel == REG_CTRL) begin
            st_d.ctrl.en     = bus_wdata[CTRL_EN];
            st_d.ctrl.irq_en = bus_wdata[CTRL_IE];
            st_d.ctrl.deb    = bus_wdata[DEB_LSB +: DEB_W];
            st_d.ctrl.thr    = bus_wdata[THR_LSB +: THR_W];
        end
        hit = (st_q.ctrl.thr != '0) && (int'(count) >= int'(st_q.ctrl.thr));
        clr = bus_wr && sel == REG_STAT && bus_wdata[STAT_THR];
        st_d.thr_st = (st_q.thr_st && !clr) || hit;
        if (bus_rd) begin
            case (sel)
                REG_CTRL:   st_d.rdata = ctrl_word(st_q.ctrl);
                REG_STAT:   st_d.rdata = stat_word(count, st_q.thr_st);
                REG_ENT_LO: st_d.rdata = head[WORD_W-1:0];
                default:    st_d.rdata = head[SNAP_W-1:WORD_W];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unused_wdata = ^{bus_wdata[WORD_W-1:THR_LSB+THR_W], bus_wdata[1]};
    assign pop          = bus_rd && (sel == REG_ENT_HI);
    assign bus_rdata    = st_q.rdata;
    assign ctrl         = st_q.ctrl;
    assign thr_status   = st_q.thr_st;
    assign irq          = st_q.thr_st && st_q.ctrl.irq_en;
endmodule

// File: rtl/keysnap_fifo.sv
module keysnap_fifo
    import keysnap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_valid,
    input  logic [SNAP_W-1:0] snap_data,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              scan_enable,
    output logic [DEB_W-1:0]  scan_debounce
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SNAP_W-1:0] head;
    logic [CNT_W-1:0]  occ;
    logic              pop, thr_status;
    ctrl_t             ctrl;

    keysnap_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (snap_valid && ctrl.en),
        .pop     (pop),
        .wr_data (snap_data),
        .head    (head),
        .count   (occ)
    );

    keysnap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count      (occ),
        .head       (head),
        .bus_rdata  (bus_rdata),
        .pop        (pop),
        .ctrl       (ctrl),
        .thr_status (thr_status),
        .irq        (irq)
    );

    assign scan_enable   = ctrl.en;
    assign scan_debounce = ctrl.deb;
endmodule

module keysnap_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snap_valid,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             irq,
    input logic             scan_enable,
    input logic [CNT_W-1:0] occ,
    input logic [3:0]       thr,
    input logic             thr_status
);
    logic hi_read;
    assign hi_read = bus_rd && (bus_addr == 2'd3);

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == DEPTH && !hi_read) |=> $stable(occ));

    assert_disabled_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_enable && !hi_read) |=> $stable(occ));

    assert_empty_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !(snap_valid && scan_enable)) |=> occ == '0);

    assert_thr_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0 && int'(occ) >= int'(thr)) |=> thr_status);

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> thr_status);
endmodule

bind keysnap_fifo keysnap_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snap_valid  (snap_valid),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .irq         (irq),
    .scan_enable (scan_enable),
    .occ         (occ),
    .thr         (ctrl.thr),
    .thr_status  (thr_status)
);

// File: tb/keysnap_fifo_bench.sv
module keysnap_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int NVEC       = 6;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_0000_0000_0000,
        64'h0000_0000_0000_0095,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8081_8283_8485_8687,
        64'hDEAD_BEEF_0123_4567,
        64'hF800_0000_00BA_8C95
    };

    logic        clk = 0, rst_n = 0;
    logic        snap_valid = 0, bus_wr = 0, bus_rd = 0;
    logic [63:0] snap_data = '0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, scan_enable;
    logic [9:0]  scan_debounce;
    int          n_chk = 0, n_bad = 0;
    logic        done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keysnap_fifo #(.DEPTH(DEPTH)) u_keysnap_fifo (
        .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_data(snap_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .scan_enable(scan_enable),
        .scan_debounce(scan_debounce)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic push(input logic [63:0] s);
        @(negedge clk); snap_valid = 1; snap_data = s;
        @(negedge clk); snap_valid = 0;
    endtask

    function automatic logic [63:0] fill_snap(input int i);
        return {32'(i) + 32'hA0B0_0000, 32'(i) * 32'h0101_0101};
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(2'd0, d); check("R1 ctrl", d, 32'h0);
        rd(2'd1, d); check("R1 status", d, 32'h0);

        // R11 control readback with junk bits masked
        wr(2'd0, 32'h0000_D559 | 32'hFFF0_0006);
        rd(2'd0, d); check("R11 ctrl readback", d, 32'h0000_D559);
        check("R11 scan_enable", {31'b0, scan_enable}, 32'h1);
        check("R11 scan_debounce", {22'b0, scan_debounce}, 32'h155);

        // R6 empty reads
        rd(2'd2, d); check("R6 empty lo", d, 32'h0);
        rd(2'd3, d); check("R6 empty hi", d, 32'h0);
        rd(2'd1, d); check("R6 empty occupancy", d, 32'h0);

        // vector table: R4 packing, R5 pop, R7 occupancy, R12 read timing
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i]);
            idle();
            rd(2'd1, d); check("R7 occupancy one", d, 32'h10);
            rd(2'd2, d); check("R4 low word", d, VEC[i][31:0]);
            rd(2'd3, d); check("R4 high word", d, VEC[i][63:32]);
            rd(2'd1, d); check("R5 popped", d, 32'h0);
        end

        // R8 threshold 3, R10 interrupt, R9 clear rules
        push(VEC[1]); push(VEC[3]);
        idle();
        rd(2'd1, d); check("R8 below threshold", d, 32'h20);
        check("R10 irq low below threshold", {31'b0, irq}, 32'h0);
        push(VEC[4]);
        idle();
        check("R10 irq high", {31'b0, irq}, 32'h1);
        rd(2'd1, d); check("R8 threshold reached", d, 32'h34);
        wr(2'd1, 32'h0);
        rd(2'd1, d); check("R9 write zero no effect", d, 32'h34);
        wr(2'd1, 32'h4);
        rd(2'd1, d); check("R9 clear loses to live condition", d, 32'h34);
        rd(2'd2, d); check("R5 order lo first", d, VEC[1][31:0]);
        rd(2'd3, d); check("R5 order hi first", d, VEC[1][63:32]);
        idle();
        rd(2'd1, d); check("R9 sticky after drop", d, 32'h24);
        wr(2'd1, 32'h4);
        rd(2'd1, d); check("R9 cleared", d, 32'h20);
        check("R10 irq low after clear", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_C001);
        push(VEC[5]);
        idle();
        rd(2'd1, d); check("R8 set with irq disabled", d, 32'h34);
        check("R10 irq gated by enable", {31'b0, irq}, 32'h0);
        rd(2'd3, d); check("R5 order second", d, VEC[3][63:32]);
        rd(2'd3, d); check("R5 order third", d, VEC[4][63:32]);
        rd(2'd3, d); check("R5 order fourth", d, VEC[5][63:32]);
        rd(2'd1, d); check("R9 sticky when drained", d, 32'h04);
        wr(2'd1, 32'h4);
        rd(2'd1, d); check("R9 cleared when empty", d, 32'h0);

        // R2 offers ignored while disabled
        wr(2'd0, 32'h0);
        check("R11 scan_enable off", {31'b0, scan_enable}, 32'h0);
        push(VEC[2]);
        idle();
        rd(2'd1, d); check("R2 disabled no push", d, 32'h0);
        rd(2'd2, d); check("R2 disabled no data", d, 32'h0);

        // R3 overflow drop, R8 threshold zero never sets
        wr(2'd0, 32'h1);
        for (int i = 0; i < DEPTH; i++) push(fill_snap(i));
        push(64'hBADB_ADBA_DBAD_BADB);
        idle();
        rd(2'd1, d); check("R3 full occupancy, R8 zero threshold", d, 32'h80);
        for (int i = 0; i < DEPTH; i++) begin
            logic [63:0] e;
            e = fill_snap(i);
            rd(2'd2, d); check("R3 kept lo", d, e[31:0]);
            rd(2'd3, d); check("R3 kept hi", d, e[63:32]);
        end
        rd(2'd2, d); check("R3 extra dropped", d, 32'h0);
        rd(2'd3, d); check("R6 pop on empty", d, 32'h0);
        rd(2'd1, d); check("R6 occupancy stays zero", d, 32'h0);

        // R5 low-word reads do not pop
        push(VEC[3]);
        rd(2'd2, d); check("R5 lo read one", d, VEC[3][31:0]);
        rd(2'd2, d); check("R5 lo read two", d, VEC[3][31:0]);
        rd(2'd1, d); check("R5 lo no pop", d, 32'h10);
        rd(2'd3, d); check("R5 hi pops", d, VEC[3][63:32]);
        rd(2'd1, d); check("R5 empty after hi", d, 32'h0);
        idle();
        check("R12 rdata held", bus_rdata, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule